// File: doc/BRIEF.md
# Sequential Radix-2 Unsigned Divider

This block divides one unsigned WIDTH-bit integer by another, one quotient bit per iteration, and returns a WIDTH-bit quotient and a WIDTH-bit remainder. A single datapath serves two schedules, chosen for each operation by an input sampled at launch. The first schedule subtracts the divisor every step and adds it back when the partial remainder goes negative. The second schedule keeps a negative partial remainder and adds the divisor on the next step instead. It then applies one final correction to the remainder. Both schedules return the same numbers.

A caller drives the operands and pulses `start` while the unit is idle. `busy` stays high while iterations run. `done` pulses for one cycle when the results are valid, and the results then hold until the next accepted launch. A zero divisor finishes at once with a flag raised and fixed results. The working registers are a WIDTH+1-bit signed partial remainder, a WIDTH-bit shift register that starts with the dividend and ends with the quotient, and a divisor register.

Top module: `seq_divider`

## Requirements
- R1: After reset, `busy`, `done` and `div_zero` are 0, and `quotient` and `remainder` are 0.
- R2: With `alg_nr` = 0 (restore schedule), a launch with a nonzero divisor returns quotient = floor(dividend/divisor) and remainder = dividend mod divisor.
- R3: With `alg_nr` = 1 (non-restoring schedule), a launch with a nonzero divisor returns the same quotient and remainder as R2.
- R4: In the restore schedule, `busy` is high for WIDTH + z cycles, where z is the number of 0 bits in the WIDTH-bit quotient. Each of the WIDTH iterations takes one cycle, and each iteration that yields a 0 bit takes one extra restore cycle.
- R5: In the non-restoring schedule, `busy` is high for exactly WIDTH + 1 cycles: one cycle per iteration and one correction cycle.
- R6: A launch with divisor 0 never raises `busy`. In the next cycle it asserts `done` with `div_zero` = 1, `quotient` all ones and `remainder` equal to the dividend.
- R7: `done` is a single-cycle pulse during which `busy` is low. `quotient` and `remainder` keep their values until the next accepted launch completes.
- R8: `start` is ignored while `busy` is high. Operands presented with it do not change the result or the cycle count of the operation in flight.
- R9: `div_zero` returns to 0 when a launch with a nonzero divisor is accepted.
- R10: On every nonzero-divisor completion, remainder < divisor and quotient*divisor + remainder = dividend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, accepted only while idle |
| alg_nr | input | 1 | 0 = restore schedule, 1 = non-restoring schedule |
| dividend | input | WIDTH | Unsigned dividend, sampled at launch |
| divisor | input | WIDTH | Unsigned divisor, sampled at launch |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle completion pulse |
| div_zero | output | 1 | Last accepted launch had a zero divisor |
| quotient | output | WIDTH | Quotient result |
| remainder | output | WIDTH | Remainder result |

## Verification
The hardest case to reach is a partial remainder that leaves the WIDTH-bit range only when shifted. This happens when the divisor has its top bit set, so the shifted value needs the extra sign bit and modular wrap. The non-restoring final correction is also hard to reach, because it runs only when the last step leaves a negative value. The stimulus sweeps both schedules over a grid that includes divisors above half range and the all-ones dividend. It also adds directed cases whose last quotient bit is 0. The restore cycle count is checked against the quotient's zero-bit count, which shows that every restore cycle really took place.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RSUB,
    ST_RRES,
    ST_NITER,
    ST_NFIX
  } div_state_e;
endpackage

// File: rtl/div_addsub.sv
module div_addsub #(
  parameter int AW = 9
) (
  input  logic [AW-1:0] op_a,
  input  logic [AW-1:0] op_b,
  input  logic          do_sub,
  output logic [AW-1:0] sum
);
  always_comb begin
    if (do_sub) sum = op_a - op_b;
    else        sum = op_a + op_b;
  end
endmodule

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       alg_nr,
  input  logic       dvs_zero,
  input  logic       res_neg,
  output div_state_e state,
  output logic       accept,
  output logic       fin
);
  localparam int CW = $clog2(WIDTH + 1);

  div_state_e state_nxt;
  logic [CW-1:0] cnt, cnt_nxt;
  logic last;

  assign last = (cnt == CW'(WIDTH - 1));

  always_comb begin
    state_nxt = state;
    cnt_nxt   = cnt;
    fin       = 1'b0;
    accept    = (state == ST_IDLE) && start;
    case (state)
      ST_IDLE: begin
        if (accept) begin
          cnt_nxt = '0;
          if (!dvs_zero) state_nxt = alg_nr ? ST_NITER : ST_RSUB;
        end
      end
      ST_RSUB: begin
        cnt_nxt = cnt + 1'b1;
        if (res_neg) begin
          state_nxt = ST_RRES;
        end else if (last) begin
          fin       = 1'b1;
          state_nxt = ST_IDLE;
        end
      end
      ST_RRES: begin
        if (cnt == CW'(WIDTH)) begin
          fin       = 1'b1;
          state_nxt = ST_IDLE;
        end else begin
          state_nxt = ST_RSUB;
        end
      end
      ST_NITER: begin
        cnt_nxt = cnt + 1'b1;
        if (last) state_nxt = ST_NFIX;
      end
      ST_NFIX: begin
        fin       = 1'b1;
        state_nxt = ST_IDLE;
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= state_nxt;
      cnt   <= cnt_nxt;
    end
  end
endmodule

// File: rtl/seq_divider.sv
module seq_divider
  import div_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             alg_nr,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic             div_zero,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);
  localparam int AW = WIDTH + 1;

  div_state_e state;
  logic accept, fin, dvs_zero;
  logic [AW-1:0] a_q, a_nxt, shifted, op_a, op_b, res;
  logic [WIDTH-1:0] q_q, q_nxt, m_q, m_nxt;
  logic do_sub, dp_en;
  logic [WIDTH-1:0] quot_nxt, rem_nxt;
  logic done_nxt, dz_nxt, res_en;

  assign dvs_zero = (divisor == '0);
  assign shifted  = {a_q[AW-2:0], q_q[WIDTH-1]};
  assign op_b     = {1'b0, m_q};

  always_comb begin
    op_a   = a_q;
    do_sub = 1'b0;
    case (state)
      ST_RSUB:  begin op_a = shifted; do_sub = 1'b1;          end
      ST_NITER: begin op_a = shifted; do_sub = ~a_q[AW-1];    end
      default:  begin op_a = a_q;     do_sub = 1'b0;          end
    endcase
  end

  div_addsub #(.AW(AW)) u_addsub (
    .op_a  (op_a),
    .op_b  (op_b),
    .do_sub(do_sub),
    .sum   (res)
  );

  div_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .alg_nr  (alg_nr),
    .dvs_zero(dvs_zero),
    .res_neg (res[AW-1]),
    .state   (state),
    .accept  (accept),
    .fin     (fin)
  );

  // Datapath next state
  always_comb begin
    a_nxt = a_q;
    q_nxt = q_q;
    m_nxt = m_q;
    dp_en = 1'b1;
    case (state)
      ST_IDLE: begin
        dp_en = accept;
        a_nxt = '0;
        q_nxt = dividend;
        m_nxt = divisor;
      end
      ST_RSUB, ST_NITER: begin
        a_nxt = res;
        q_nxt = {q_q[WIDTH-2:0], ~res[AW-1]};
      end
      ST_RRES: a_nxt = res;
      ST_NFIX: if (a_q[AW-1]) a_nxt = res;
      default: dp_en = 1'b0;
    endcase
  end

  // Result next state
  always_comb begin
    done_nxt = fin || (accept && dvs_zero);
    res_en   = done_nxt;
    dz_nxt   = div_zero;
    quot_nxt = quotient;
    rem_nxt  = remainder;
    if (accept) dz_nxt = dvs_zero;
    if (accept && dvs_zero) begin
      quot_nxt = '1;
      rem_nxt  = dividend;
    end else if (fin) begin
      quot_nxt = q_nxt;
      rem_nxt  = a_nxt[WIDTH-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      q_q <= '0;
      m_q <= '0;
    end else if (dp_en) begin
      a_q <= a_nxt;
      q_q <= q_nxt;
      m_q <= m_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      div_zero  <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
    end else begin
      done     <= done_nxt;
      div_zero <= dz_nxt;
      if (res_en) begin
        quotient  <= quot_nxt;
        remainder <= rem_nxt;
      end
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/seq_divider_chk.sv
module seq_divider_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             alg_nr,
  input logic [WIDTH-1:0] dividend,
  input logic [WIDTH-1:0] divisor,
  input logic             busy,
  input logic             done,
  input logic             div_zero,
  input logic [WIDTH-1:0] quotient,
  input logic [WIDTH-1:0] remainder
);
  logic [WIDTH-1:0] cap_dvd, cap_dvs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_dvd <= '0;
      cap_dvs <= '0;
    end else if (start && !busy) begin
      cap_dvd <= dividend;
      cap_dvs <= divisor;
    end
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_hold_results_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(quotient) && $stable(remainder)));

  assert_zero_path_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && divisor == '0) |=> (done && div_zero && !busy && quotient == '1));

  assert_zero_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && divisor != '0) |=> !div_zero);

  assert_rem_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_zero) |-> (remainder < cap_dvs));

  assert_identity_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_zero) |->
      ((2*WIDTH)'(quotient) * (2*WIDTH)'(cap_dvs) + (2*WIDTH)'(remainder) == (2*WIDTH)'(cap_dvd)));

  assert_launch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

bind seq_divider seq_divider_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/seq_divider_tb.sv
module seq_divider_tb_top;
  localparam int W = 8;

  logic clk, rst_n, start, alg_nr;
  logic [W-1:0] dividend, divisor, quotient, remainder;
  logic busy, done, div_zero;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  seq_divider #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .alg_nr(alg_nr),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .div_zero(div_zero), .quotient(quotient), .remainder(remainder)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // One division; poke=1 raises start with other operands mid-run (R8)
  task automatic run_div(input logic nr, input logic [W-1:0] dvd,
                         input logic [W-1:0] dvs, input bit poke);
    logic [W-1:0] eq, er;
    int elat, lat;
    if (dvs == 0) begin
      eq = '1; er = dvd; elat = 0;
    end else begin
      eq = dvd / dvs; er = dvd % dvs;
      elat = nr ? W + 1 : W + (W - $countones(eq));
    end
    @(negedge clk);
    start = 1'b1; alg_nr = nr; dividend = dvd; divisor = dvs;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (busy && lat < 100) begin
      lat++;
      if (poke && lat == 2) begin
        start = 1'b1; alg_nr = ~nr; dividend = ~dvd; divisor = dvs ^ 8'h5A;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(poke ? "R8 done" : "R7 done", done, 1);
    check(nr ? "R3 quotient" : "R2 quotient", quotient, eq);
    check(nr ? "R3 remainder" : "R2 remainder", remainder, er);
    if (dvs == 0) check("R6 latency", lat, 0);
    else if (nr) check("R5 latency", lat, elat);
    else check("R4 latency", lat, elat);
    check(dvs == 0 ? "R6 div_zero" : "R9 div_zero", div_zero, dvs == 0);
  endtask

  task automatic test_reset;
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 div_zero", div_zero, 0);
    check("R1 quotient", quotient, 0);
    check("R1 remainder", remainder, 0);
  endtask

  task automatic test_hold;
    run_div(1'b0, 8'd200, 8'd13, 1'b0);
    @(negedge clk);
    check("R7 done low", done, 0);
    repeat (3) @(negedge clk);
    check("R7 quotient held", quotient, 15);
    check("R7 remainder held", remainder, 5);
  endtask

  task automatic test_sweep;
    for (int a = 0; a < 256; a += 17)
      for (int b = 1; b < 256; b += 23) begin
        run_div(1'b0, W'(a), W'(b), 1'b0);
        run_div(1'b1, W'(a), W'(b), 1'b0);
      end
  endtask

  task automatic test_corners;
    logic [W-1:0] dv [8] = '{8'd255, 8'd255, 8'd0, 8'd5, 8'd128, 8'd254, 8'd7, 8'd200};
    logic [W-1:0] ds [8] = '{8'd1, 8'd255, 8'd5, 8'd255, 8'd129, 8'd255, 8'd2, 8'd201};
    for (int i = 0; i < 8; i++) begin
      run_div(1'b0, dv[i], ds[i], 1'b0);
      run_div(1'b1, dv[i], ds[i], 1'b0);
    end
  endtask

  task automatic test_zero;
    run_div(1'b0, 8'd77, 8'd0, 1'b0);
    run_div(1'b1, 8'd0, 8'd0, 1'b0);
    run_div(1'b1, 8'd9, 8'd3, 1'b0);
  endtask

  task automatic test_ignore;
    run_div(1'b0, 8'd221, 8'd6, 1'b1);
    run_div(1'b1, 8'd143, 8'd200, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; alg_nr = 1'b0; dividend = '0; divisor = '0;
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_hold();
    test_corners();
    test_zero();
    test_ignore();
    test_sweep();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule